// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This engine moves sector data between a disk-side buffer port and system memory by walking a table of region descriptors held in memory. The device state machine sets up a command. It arms the engine with the command's byte budget and the transfer direction. A later start request supplies the table base address. The engine then fetches each 8-byte descriptor, moves that region one 512-byte sector at a time over a request/grant memory port, and chains to the next descriptor until one carries the end-of-table flag.

The memory port is a single-beat master. A request is granted, or refused with busy, in the same cycle. After a busy cycle the engine goes quiet for a fixed backoff period and then reissues the identical request. The engine watches the command budget on every descriptor. It reports completion or error back to the device state machine with single-cycle pulses. An abort from the device side ends any active transfer with an error.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, `done_o` and `err_o` low, `rem_bytes_o` and `dsk_sect_o` zero.
- R2: `arm_i` in the idle state latches `cmd_bytes_i` into `rem_bytes_o`, latches the direction, clears `dsk_sect_o` and enters the armed state. `start_i` is accepted only in the armed state, where it loads `tbl_base_i` as the table pointer. `start_i` while idle has no effect and produces no memory request.
- R3: A descriptor is fetched as two word reads, at the table pointer and at pointer+4. The pointer then advances by 8. Word 0 is the region base address. In word 1, bits 15:0 are the byte count, where 0 means 65536, and bit 31 is the end-of-table flag.
- R4: Region data moves in 128-word (512-byte) sectors, with the byte count rounded up to whole sectors. Word addresses start at the region base and step by 4. Each completed sector lowers `rem_bytes_o` by 512 and raises `dsk_sect_o` by 1.
- R5: With `dir_to_mem_i`=0, the engine reads memory (`mem_we_o`=0) and each granted word appears on `dsk_wdata_o` with `dsk_wr_o` in the same cycle. With `dir_to_mem_i`=1, it writes memory (`mem_we_o`=1) with `dsk_rdata_i`, and `dsk_rd_o` pops the disk word in the grant cycle.
- R6: A descriptor whose rounded size exceeds the remaining budget pulses `err_o` for one cycle, returns the engine to idle and moves no data.
- R7: After the last sector of a descriptor with the end-of-table flag set, the engine returns to idle and pulses `done_o` for one cycle. If the remaining budget is then not zero, `err_o` pulses in the same cycle. Without the flag, the next descriptor is fetched at the advanced pointer.
- R8: A request that meets `mem_busy_i` is dropped for BACKOFF cycles (default 4) and then reissued with the same address and direction.
- R9: `abort_i` outside the idle state returns the engine to idle and pulses `err_o` the next cycle. `abort_i` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm engine for a new command (idle only) |
| dir_to_mem_i | input | 1 | 1: disk to memory, 0: memory to disk |
| cmd_bytes_i | input | LEN_W | Command byte budget |
| start_i | input | 1 | Start walking the table (armed only) |
| tbl_base_i | input | AW | Descriptor table base address |
| abort_i | input | 1 | Abort active transfer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_busy_i | input | 1 | Bus busy, request refused |
| mem_rdata_i | input | 32 | Memory read data, valid with grant |
| dsk_wr_o | output | 1 | Push word into disk buffer |
| dsk_wdata_o | output | 32 | Word for disk buffer |
| dsk_rd_o | output | 1 | Pop word from disk buffer |
| dsk_rdata_i | input | 32 | Head word of disk buffer |
| dsk_sect_o | output | SECT_W | Sectors completed in this command |
| rem_bytes_o | output | LEN_W | Remaining command bytes |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Error pulse |

## Verification
The bench targets several corner cases, each tied to a specific failure. A zero byte count must move 65536 bytes; a design that reads it literally finishes at once. A 100-byte region must still move a full sector; a design that truncates moves nothing. An oversized descriptor must fail before any data moves; a late check would first leak words to memory. The end-of-table flag must also be checked against a budget that is not yet spent, or a short chain would report clean success. Busy cycles during descriptor fetch and during data movement must yield exactly the backoff gap and the same address on retry; a design that skips or advances on a refused beat would corrupt the captured data stream. Aborts are issued in the armed state, mid-sector and while idle, to show that only the first two report an error.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_FETCH0,
    ST_FETCH1,
    ST_MOVE
  } sg_state_e;

  localparam int DESC_STEP  = 8;
  localparam int WORD_BYTES = 4;
  localparam int EOT_BIT    = 31;
  localparam int DW         = 32;
endpackage

// File: rtl/sg_backoff.sv
module sg_backoff #(
  parameter int BACKOFF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic hold_o
);
  localparam int CW = $clog2(BACKOFF + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(BACKOFF);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign hold_o = (cnt_q != '0);

  AST_BACKOFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> hold_o); // R8
endmodule

// File: rtl/sg_desc_decode.sv
module sg_desc_decode #(
  parameter int LEN_W   = 18,
  parameter int SECT_LG = 9,
  parameter int NSEC_W  = 8
) (
  input  logic [15:0]       cnt_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [NSEC_W-1:0] nsec_o,
  output logic              fits_o
);
  localparam int CMPW = LEN_W + 18;

  logic [16:0]     bytes_w;
  logic [16:0]     rnd_w;
  logic [CMPW-1:0] need_w;

  always_comb begin
    bytes_w = (cnt_i == 16'd0) ? 17'h10000 : {1'b0, cnt_i};
    rnd_w   = bytes_w + 17'((1 << SECT_LG) - 1);   // round up to whole sectors
    nsec_o  = NSEC_W'(rnd_w >> SECT_LG);
    need_w  = CMPW'(nsec_o) << SECT_LG;
    fits_o  = (need_w <= CMPW'(rem_i));
  end
endmodule

// File: rtl/sg_word_cnt.sv
module sg_word_cnt #(
  parameter int WPS_LG = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  logic [WPS_LG-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + WPS_LG'(1);
  end

  assign last_o = &cnt_q;

  AST_CLR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !last_o); // R4
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_W   = 18,
  parameter int SECT_LG = 9,
  parameter int SECT_W  = 16,
  parameter int BACKOFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              dir_to_mem_i,
  input  logic [LEN_W-1:0]  cmd_bytes_i,
  input  logic              start_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_busy_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              dsk_wr_o,
  output logic [31:0]       dsk_wdata_o,
  output logic              dsk_rd_o,
  input  logic [31:0]       dsk_rdata_i,
  output logic [SECT_W-1:0] dsk_sect_o,
  output logic [LEN_W-1:0]  rem_bytes_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int WPS_LG     = SECT_LG - 2;
  localparam int NSEC_W     = 17 - SECT_LG;
  localparam int SECT_BYTES = 1 << SECT_LG;

  sg_state_e         state_q;
  logic              dir_q, eot_q, done_q, err_q;
  logic [LEN_W-1:0]  rem_q;
  logic [SECT_W-1:0] sect_q;
  logic [AW-1:0]     ptr_q, addr_q;
  logic [NSEC_W-1:0] nsec_q, nsec_w;
  logic              fits_w, hold_w, word_last_w, xfer_w, bus_state_w;

  assign bus_state_w = (state_q == ST_FETCH0) || (state_q == ST_FETCH1) || (state_q == ST_MOVE);
  assign mem_req_o   = bus_state_w && !hold_w;
  assign xfer_w      = mem_req_o && mem_gnt_i;
  assign mem_we_o    = (state_q == ST_MOVE) && dir_q;
  assign mem_wdata_o = dsk_rdata_i;
  assign dsk_wdata_o = mem_rdata_i;
  assign dsk_wr_o    = xfer_w && (state_q == ST_MOVE) && !dir_q;
  assign dsk_rd_o    = xfer_w && (state_q == ST_MOVE) && dir_q;

  always_comb begin
    unique case (state_q)
      ST_FETCH0: mem_addr_o = ptr_q;
      ST_FETCH1: mem_addr_o = ptr_q + AW'(WORD_BYTES);
      default:   mem_addr_o = addr_q;
    endcase
  end

  sg_backoff #(.BACKOFF(BACKOFF)) u_backoff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (mem_req_o && mem_busy_i),
    .hold_o (hold_w)
  );

  sg_desc_decode #(.LEN_W(LEN_W), .SECT_LG(SECT_LG), .NSEC_W(NSEC_W)) u_decode (
    .cnt_i  (mem_rdata_i[15:0]),
    .rem_i  (rem_q),
    .nsec_o (nsec_w),
    .fits_o (fits_w)
  );

  sg_word_cnt #(.WPS_LG(WPS_LG)) u_words (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((state_q == ST_IDLE) && arm_i),
    .step_i (xfer_w && (state_q == ST_MOVE) && !abort_i),
    .last_o (word_last_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      eot_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rem_q   <= '0;
      sect_q  <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      nsec_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (abort_i && state_q != ST_IDLE) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (arm_i) begin
            state_q <= ST_ARMED;
            rem_q   <= cmd_bytes_i;
            dir_q   <= dir_to_mem_i;
            sect_q  <= '0;
          end
          ST_ARMED: if (start_i) begin
            ptr_q   <= tbl_base_i;
            state_q <= ST_FETCH0;
          end
          ST_FETCH0: if (xfer_w) begin
            addr_q  <= mem_rdata_i[AW-1:0];
            state_q <= ST_FETCH1;
          end
          ST_FETCH1: if (xfer_w) begin
            ptr_q <= ptr_q + AW'(DESC_STEP);
            if (!fits_w) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              nsec_q  <= nsec_w;
              eot_q   <= mem_rdata_i[EOT_BIT];
              state_q <= ST_MOVE;
            end
          end
          ST_MOVE: if (xfer_w) begin
            addr_q <= addr_q + AW'(WORD_BYTES);
            if (word_last_w) begin
              rem_q  <= rem_q - LEN_W'(SECT_BYTES);
              sect_q <= sect_q + SECT_W'(1);
              nsec_q <= nsec_q - NSEC_W'(1);
              if (nsec_q == NSEC_W'(1)) begin
                if (eot_q) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  err_q   <= (rem_q != LEN_W'(SECT_BYTES));
                end else begin
                  state_q <= ST_FETCH0;
                end
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign dsk_sect_o  = sect_q;
  assign rem_bytes_o = rem_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  AST_IDLE_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !arm_i) |=> !mem_req_o); // R2
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH1 && xfer_w && !abort_i) |=> (ptr_q == $past(ptr_q) + AW'(DESC_STEP))); // R3
  AST_REM_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (rem_q <= $past(rem_q))); // R4
  AST_OVERRUN_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH1 && xfer_w && !fits_w && !abort_i) |=> (err_q && !mem_req_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R7
  AST_ABORT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && state_q != ST_IDLE) |=> (err_q && state_q == ST_IDLE)); // R9
endmodule

// File: tb/tb_sg_dma_engine.sv
`timescale 1ns/1ps
module tb_sg_dma_engine;
  localparam int AW = 32;
  localparam int LEN_W = 18;
  localparam int BO = 4;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              arm_i = 0, dir_i = 0, start_i = 0, abort_i = 0, busy_i = 0;
  logic [LEN_W-1:0]  cmd_i = '0;
  logic [AW-1:0]     base_i = '0;
  logic              mem_req_o, mem_we_o, mem_gnt_i, dsk_wr_o, dsk_rd_o, done_o, err_o;
  logic [AW-1:0]     mem_addr_o;
  logic [31:0]       mem_wdata_o, mem_rdata_i, dsk_wdata_o, dsk_rdata_i;
  logic [15:0]       dsk_sect_o;
  logic [LEN_W-1:0]  rem_bytes_o;

  logic [31:0] tbl [0:31];
  logic [31:0] pop_cnt = 0;
  logic [31:0] sink_q [$];
  logic [31:0] wra_q [$];
  logic [31:0] wrd_q [$];
  int checks = 0, errors = 0, cyc = 0;
  bit busy_en = 0;

  sg_dma_engine #(.AW(AW), .LEN_W(LEN_W), .BACKOFF(BO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm_i), .dir_to_mem_i(dir_i), .cmd_bytes_i(cmd_i),
    .start_i(start_i), .tbl_base_i(base_i), .abort_i(abort_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i(mem_gnt_i), .mem_busy_i(busy_i), .mem_rdata_i(mem_rdata_i),
    .dsk_wr_o(dsk_wr_o), .dsk_wdata_o(dsk_wdata_o), .dsk_rd_o(dsk_rd_o), .dsk_rdata_i(dsk_rdata_i),
    .dsk_sect_o(dsk_sect_o), .rem_bytes_o(rem_bytes_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 ^ a;
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a[31:7] == 25'd2) return tbl[a[6:2]];
    return pat(a);
  endfunction

  assign mem_gnt_i   = mem_req_o && !busy_i;
  assign dsk_rdata_i = 32'hD15C_0000 + pop_cnt;
  always_comb mem_rdata_i = rd_word(mem_addr_o);

  always @(posedge clk) begin
    if (dsk_rd_o) pop_cnt <= pop_cnt + 1;
    if (dsk_wr_o) sink_q.push_back(dsk_wdata_o);
    if (mem_gnt_i && mem_we_o) begin
      wra_q.push_back(mem_addr_o);
      wrd_q.push_back(mem_wdata_o);
    end
  end

  // behavioural reference model
  int m_phase, m_bo, m_wleft, m_wsec, m_rem, m_sect, m_nsec, m_bytes;
  logic [31:0] m_ptr, m_addr, m_w;
  bit m_dir, m_eot, m_done, m_err, m_req, m_gnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_bo = 0; m_wleft = 0; m_wsec = 0; m_rem = 0; m_sect = 0;
      m_ptr = 0; m_addr = 0; m_dir = 0; m_eot = 0; m_done = 0; m_err = 0;
    end else begin
      m_req = (m_phase >= 2) && (m_bo == 0);
      m_gnt = m_req && !busy_i;
      m_done = 0; m_err = 0;
      if (m_bo > 0) m_bo--;
      if (m_req && busy_i) m_bo = BO;
      if (abort_i && m_phase != 0) begin
        m_phase = 0; m_err = 1;
      end else begin
        case (m_phase)
          0: if (arm_i) begin m_phase = 1; m_rem = int'(cmd_i); m_dir = dir_i; m_sect = 0; m_wsec = 0; end
          1: if (start_i) begin m_phase = 2; m_ptr = base_i; end
          2: if (m_gnt) begin m_addr = rd_word(m_ptr); m_phase = 3; end
          3: if (m_gnt) begin
            m_w = rd_word(m_ptr + 4);
            m_ptr = m_ptr + 8;
            m_bytes = (m_w[15:0] == 0) ? 65536 : int'(m_w[15:0]);
            m_nsec = (m_bytes + 511) / 512;
            m_eot = m_w[31];
            if (m_nsec * 512 > m_rem) begin m_err = 1; m_phase = 0; end
            else begin m_wleft = m_nsec * 128; m_phase = 4; end
          end
          4: if (m_gnt) begin
            m_addr = m_addr + 4; m_wleft--; m_wsec++;
            if (m_wsec == 128) begin m_wsec = 0; m_rem -= 512; m_sect++; end
            if (m_wleft == 0) begin
              if (m_eot) begin m_phase = 0; m_done = 1; if (m_rem != 0) m_err = 1; end
              else m_phase = 2;
            end
          end
          default: m_phase = 0;
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp("R8 req", 64'(mem_req_o), 64'((m_phase >= 2) && (m_bo == 0)));
      if (mem_req_o) begin
        cmp("R3/R4 addr", 64'(mem_addr_o),
            64'((m_phase == 2) ? m_ptr : (m_phase == 3) ? m_ptr + 4 : m_addr));
        cmp("R5 we", 64'(mem_we_o), 64'((m_phase == 4) && m_dir));
      end
      cmp("R7 done", 64'(done_o), 64'(m_done));
      cmp("R6/R7/R9 err", 64'(err_o), 64'(m_err));
      cmp("R4 rem", 64'(rem_bytes_o), 64'(m_rem));
      cmp("R4 sect", 64'(dsk_sect_o), 64'(m_sect));
    end
    busy_i <= busy_en && (cyc % 29 == 3);
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit dir, input int cmd, input logic [31:0] base, output bit d, output bit e);
    int n;
    @(negedge clk); arm_i = 1; dir_i = dir; cmd_i = LEN_W'(cmd);
    @(negedge clk); arm_i = 0; start_i = 1; base_i = base;
    @(negedge clk); start_i = 0;
    n = 0;
    while (!(done_o || err_o) && n < 100000) begin @(negedge clk); n++; end
    d = done_o; e = err_o;
  endtask

  initial begin
    bit d, e;
    logic [31:0] pbase;
    for (int i = 0; i < 32; i++) tbl[i] = 32'h0;
    tbl[0]  = 32'h0001_0000; tbl[1]  = 32'h0000_0200;
    tbl[2]  = 32'h0002_0000; tbl[3]  = 32'h8000_0400;
    tbl[4]  = 32'h0003_0000; tbl[5]  = 32'h8000_0400;
    tbl[6]  = 32'h0004_0000; tbl[7]  = 32'h8000_0400;
    tbl[8]  = 32'h0005_0000; tbl[9]  = 32'h8000_0200;
    tbl[10] = 32'h0006_0000; tbl[11] = 32'h8000_0064;
    tbl[12] = 32'h0010_0000; tbl[13] = 32'h8000_0000;
    tbl[14] = 32'h0007_0000; tbl[15] = 32'h8000_0400;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 req", 64'(mem_req_o), 0);
    cmp("R1 done/err", 64'({done_o, err_o}), 0);
    cmp("R1 rem", 64'(rem_bytes_o), 0);
    cmp("R1 sect", 64'(dsk_sect_o), 0);

    // R2 start while idle is ignored
    start_i = 1; base_i = 32'h100;
    @(negedge clk); start_i = 0;
    for (int i = 0; i < 10; i++) begin cmp("R2 idle start no req", 64'(mem_req_o), 0); @(negedge clk); end

    // R3 R5 R8: two-descriptor chain, memory to disk, busy injected
    busy_en = 1;
    sink_q.delete();
    run(0, 1536, 32'h100, d, e);
    busy_en = 0;
    cmp("R7 chain done", 64'(d), 1);
    cmp("R7 chain no err", 64'(e), 0);
    cmp("R5 sink count", 64'(sink_q.size()), 384);
    for (int i = 0; i < 384 && i < sink_q.size(); i++) begin
      logic [31:0] ea;
      ea = (i < 128) ? 32'h1_0000 + 32'(4 * i) : 32'h2_0000 + 32'(4 * (i - 128));
      if (sink_q[i] !== pat(ea)) cmp("R5 sink data", 64'(sink_q[i]), 64'(pat(ea)));
    end
    cmp("R4 sect after chain", 64'(dsk_sect_o), 3);

    // R5 disk to memory
    wra_q.delete(); wrd_q.delete();
    pbase = pop_cnt;
    run(1, 1024, 32'h110, d, e);
    cmp("R5 d2m done", 64'({d, e}), 64'(2'b10));
    cmp("R5 write count", 64'(wra_q.size()), 256);
    for (int i = 0; i < 256 && i < wra_q.size(); i++) begin
      if (wra_q[i] !== 32'h3_0000 + 32'(4 * i)) cmp("R5 write addr", 64'(wra_q[i]), 64'(32'h3_0000 + 32'(4 * i)));
      if (wrd_q[i] !== 32'hD15C_0000 + pbase + 32'(i)) cmp("R5 write data", 64'(wrd_q[i]), 64'(32'hD15C_0000 + pbase + 32'(i)));
    end

    // R6 descriptor larger than budget
    sink_q.delete();
    run(0, 512, 32'h118, d, e);
    cmp("R6 overrun err", 64'({d, e}), 64'(2'b01));
    cmp("R6 no data", 64'(sink_q.size()), 0);
    cmp("R6 rem kept", 64'(rem_bytes_o), 512);

    // R7 end of table with budget left
    run(0, 1024, 32'h120, d, e);
    cmp("R7 short chain done+err", 64'({d, e}), 64'(2'b11));
    cmp("R7 rem left", 64'(rem_bytes_o), 512);
    @(negedge clk);
    cmp("R7 done one cycle", 64'(done_o), 0);

    // R4 byte count rounded up to one sector
    sink_q.delete();
    run(0, 512, 32'h128, d, e);
    cmp("R4 round done", 64'({d, e}), 64'(2'b10));
    cmp("R4 round words", 64'(sink_q.size()), 128);

    // R3 zero count means 65536 bytes
    sink_q.delete();
    run(0, 65536, 32'h130, d, e);
    cmp("R3 zero count done", 64'({d, e}), 64'(2'b10));
    cmp("R3 zero count words", 64'(sink_q.size()), 16384);
    if (sink_q.size() == 16384)
      cmp("R3 last word", 64'(sink_q[16383]), 64'(pat(32'h0010_0000 + 32'(4 * 16383))));
    cmp("R3 rem zero", 64'(rem_bytes_o), 0);

    // R9 abort in armed state
    @(negedge clk); arm_i = 1; dir_i = 0; cmd_i = LEN_W'(1024);
    @(negedge clk); arm_i = 0; abort_i = 1;
    @(negedge clk); abort_i = 0;
    cmp("R9 abort armed err", 64'(err_o), 1);

    // R9 abort in idle has no effect
    @(negedge clk); abort_i = 1;
    @(negedge clk); abort_i = 0;
    cmp("R9 abort idle no err", 64'(err_o), 0);

    // R9 abort mid-sector
    @(negedge clk); arm_i = 1; dir_i = 0; cmd_i = LEN_W'(1024);
    @(negedge clk); arm_i = 0; start_i = 1; base_i = 32'h138;
    @(negedge clk); start_i = 0;
    repeat (40) @(negedge clk);
    abort_i = 1;
    @(negedge clk); abort_i = 0;
    cmp("R9 abort move err", 64'(err_o), 1);
    cmp("R9 abort rem", 64'(rem_bytes_o), 1024);
    repeat (5) begin @(negedge clk); cmp("R9 quiet after abort", 64'(mem_req_o), 0); end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule